// File: doc/BRIEF.md
# Burst-of-Two Quad-Data-Rate SRAM Controller

This block sits between on-chip logic and one external burst-of-two quad-data-rate SRAM. It has two independent request channels. The read channel takes an address and a tag, and later returns the tag with a pair of words. The write channel takes an address, two data words and a byte mask for each word. Each channel can accept a request in every cycle, and a read and a write can go out together in the same cycle.

The device side is shown as one register per half-cycle. A read select and a write select, both active low, belong to the first half. The shared address bus carries the read address in the first half and the write address in the second half. Write word 0 and its byte enables belong to the first half, and word 1 and its byte enables belong to the second. A double-rate output cell outside the block multiplexes each pair onto the pins. Read data comes back as a first-half word and a second-half word. No strobe from the memory qualifies it. Instead, a valid bit and a tag travel down a pipeline as deep as the device latency and mark the returning pair.

The memory itself reads the old contents when a read and a write hit the same burst address in the same cycle. The controller therefore carries the write data and mask of that cycle next to the pending read. When the read data returns, it replaces each byte lane the write enabled. The user sees the newly written data with no stall and no reordering.

Top module: `qdr2_burst_ctrl`

## Requirements
- R1: While reset is high, both readies are low. The first edge with reset high drives both selects high and clears the response valid. It also sets the address and data buses to zero and every byte enable high. A read accepted before that edge never produces a response.
- R2: Outside reset, both readies are high in every cycle. A request accepted at a clock edge drives its select low during the following cycle. A read and a write accepted at the same edge both drive their selects low during that cycle.
- R3: In the cycle after acceptance, the first-half address bus carries the accepted read address and the second-half address bus carries the accepted write address.
- R4: In the cycle after a write is accepted, word 0 is on the first-half data bus and word 1 is on the second-half data bus. Each word's active-low byte enables are the bitwise inverse of its user mask. Mask bit i covers data bits [9i+8:9i].
- R5: A channel that has no accepted request at an edge keeps its select high for the next cycle. It also holds its address bus and, for writes, its data buses and byte enables at their previous values.
- R6: A read accepted at edge e gives a response valid for one cycle after edge e+RD_LAT+1 (RD_LAT = 2). The response carries the read's tag. Word 0 is the first-half word the device returned in the cycle after edge e+RD_LAT, and word 1 is the second-half word from that cycle. Back-to-back reads produce back-to-back responses in order.
- R7: A read and a write accepted at the same edge to the same address return, for each byte lane whose write mask bit is 1, the write data of that lane. All other lanes return the device data. Neither channel stalls.
- R8: A read paired with a write to a different address, or followed by a later write to its own address, returns the device data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rdValid | input | 1 | Read request present |
| rdReady | output | 1 | Read channel accepts |
| rdAddr | input | 18 | Read burst address |
| rdTag | input | 4 | Tag returned with the read response |
| wrValid | input | 1 | Write request present |
| wrReady | output | 1 | Write channel accepts |
| wrAddr | input | 18 | Write burst address |
| wrData0 | input | 18 | First write word |
| wrData1 | input | 18 | Second write word |
| wrMask0 | input | 2 | Byte-lane mask for word 0, 1 = write |
| wrMask1 | input | 2 | Byte-lane mask for word 1, 1 = write |
| rspValid | output | 1 | Read response present |
| rspTag | output | 4 | Tag of the response |
| rspData0 | output | 18 | First response word |
| rspData1 | output | 18 | Second response word |
| devRdSelN | output | 1 | Device read select, active low |
| devWrSelN | output | 1 | Device write select, active low |
| devAddrRise | output | 18 | Address bus, first half (read) |
| devAddrFall | output | 18 | Address bus, second half (write) |
| devDataRise | output | 18 | Write data, first half |
| devDataFall | output | 18 | Write data, second half |
| devBeRiseN | output | 2 | Byte enables, first half, active low |
| devBeFallN | output | 2 | Byte enables, second half, active low |
| devQRise | input | 18 | Read data from device, first half |
| devQFall | input | 18 | Read data from device, second half |

## Verification
A behavioural device model in the bench reads before it writes, so a same-cycle same-address pair exposes a missing bypass. Directed patterns cover several cases, and each separates a different fault:
- a lone read, which tells a latency or word-order error apart;
- a write followed by a read, which separates a write that was never committed from a misplaced one;
- same-address pairs with full, split and empty masks, which show that forwarding is done per lane rather than per word;
- a different-address pair;
- a back-to-back read train, which shows whether responses get lost or merged;
- reads in flight across a reset.

Random traffic confined to sixteen addresses then mixes all of these, with random masks, so that collisions and idle gaps occur often.

// File: rtl/qdr2_pkg.sv
package qdr2_pkg;

  // Per-cycle strobes from the control path to the datapath.
  typedef struct packed {
    logic launchRd;   // read accepted at this edge
    logic launchWr;   // write accepted at this edge
    logic fwdHit;     // read and write to the same burst address
    logic capture;    // returning word pair is to be registered
  } qdrStrobes_t;

endpackage

// File: rtl/qdr2_ctrl.sv
module qdr2_ctrl
  import qdr2_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int TAG_W  = 4,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdValid,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [TAG_W-1:0]  rdTag,
  output logic              rdReady,
  output logic              wrReady,
  output qdrStrobes_t       strb,
  output logic              devRdSelN,
  output logic              devWrSelN,
  output logic              rspValid,
  output logic [TAG_W-1:0]  rspTag
);

  localparam int STAGES = RD_LAT + 1;

  logic [STAGES-1:0] vPipe;
  logic [TAG_W-1:0]  tagPipe [STAGES];

  // Both channels take one request per cycle outside reset.
  assign rdReady = !rst;
  assign wrReady = !rst;

  always_comb begin
    strb.launchRd = rdValid & rdReady;
    strb.launchWr = wrValid & wrReady;
    strb.fwdHit   = strb.launchRd & strb.launchWr & (rdAddr == wrAddr);
    strb.capture  = vPipe[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      devRdSelN <= 1'b1;
      devWrSelN <= 1'b1;
      vPipe     <= '0;
      rspValid  <= 1'b0;
    end else begin
      devRdSelN <= ~strb.launchRd;
      devWrSelN <= ~strb.launchWr;
      vPipe     <= {vPipe[STAGES-2:0], strb.launchRd};
      rspValid  <= vPipe[STAGES-1];
    end
  end

  // Tags need no reset: the valid pipe qualifies them.
  always_ff @(posedge clk) begin
    tagPipe[0] <= rdTag;
    for (int i = 1; i < STAGES; i++) tagPipe[i] <= tagPipe[i-1];
    if (vPipe[STAGES-1]) rspTag <= tagPipe[STAGES-1];
  end

endmodule

// File: rtl/qdr2_datapath.sv
module qdr2_datapath
  import qdr2_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  parameter int RD_LAT = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  qdrStrobes_t             strb,
  input  logic [ADDR_W-1:0]       rdAddr,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [LANES*LANE_W-1:0] wrData0,
  input  logic [LANES*LANE_W-1:0] wrData1,
  input  logic [LANES-1:0]        wrMask0,
  input  logic [LANES-1:0]        wrMask1,
  input  logic [LANES*LANE_W-1:0] devQRise,
  input  logic [LANES*LANE_W-1:0] devQFall,
  output logic [ADDR_W-1:0]       devAddrRise,
  output logic [ADDR_W-1:0]       devAddrFall,
  output logic [LANES*LANE_W-1:0] devDataRise,
  output logic [LANES*LANE_W-1:0] devDataFall,
  output logic [LANES-1:0]        devBeRiseN,
  output logic [LANES-1:0]        devBeFallN,
  output logic [LANES*LANE_W-1:0] rspData0,
  output logic [LANES*LANE_W-1:0] rspData1
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int STAGES = RD_LAT + 1;

  // Bypass pipe: write data and the lanes it may override, per pending read.
  logic [DATA_W-1:0] fwdD0 [STAGES];
  logic [DATA_W-1:0] fwdD1 [STAGES];
  logic [LANES-1:0]  fwdM0 [STAGES];
  logic [LANES-1:0]  fwdM1 [STAGES];
  logic [DATA_W-1:0] mergeRise;
  logic [DATA_W-1:0] mergeFall;

  // Device bus registers: updated only on a launch, otherwise held.
  always_ff @(posedge clk) begin
    if (rst) begin
      devAddrRise <= '0;
      devAddrFall <= '0;
      devDataRise <= '0;
      devDataFall <= '0;
      devBeRiseN  <= '1;
      devBeFallN  <= '1;
    end else begin
      if (strb.launchRd) devAddrRise <= rdAddr;
      if (strb.launchWr) begin
        devAddrFall <= wrAddr;
        devDataRise <= wrData0;
        devDataFall <= wrData1;
        devBeRiseN  <= ~wrMask0;
        devBeFallN  <= ~wrMask1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) begin
        fwdM0[i] <= '0;
        fwdM1[i] <= '0;
      end
    end else begin
      fwdM0[0] <= strb.fwdHit ? wrMask0 : '0;
      fwdM1[0] <= strb.fwdHit ? wrMask1 : '0;
      for (int i = 1; i < STAGES; i++) begin
        fwdM0[i] <= fwdM0[i-1];
        fwdM1[i] <= fwdM1[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    fwdD0[0] <= wrData0;
    fwdD1[0] <= wrData1;
    for (int i = 1; i < STAGES; i++) begin
      fwdD0[i] <= fwdD0[i-1];
      fwdD1[i] <= fwdD1[i-1];
    end
  end

  // Per-lane selection between device data and forwarded write data.
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign mergeRise[g*LANE_W +: LANE_W] = fwdM0[STAGES-1][g] ?
        fwdD0[STAGES-1][g*LANE_W +: LANE_W] : devQRise[g*LANE_W +: LANE_W];
    assign mergeFall[g*LANE_W +: LANE_W] = fwdM1[STAGES-1][g] ?
        fwdD1[STAGES-1][g*LANE_W +: LANE_W] : devQFall[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (strb.capture) begin
      rspData0 <= mergeRise;
      rspData1 <= mergeFall;
    end
  end

endmodule

// File: rtl/qdr2_burst_ctrl.sv
module qdr2_burst_ctrl
  import qdr2_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  parameter int TAG_W  = 4,
  parameter int RD_LAT = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rdValid,
  output logic                    rdReady,
  input  logic [ADDR_W-1:0]       rdAddr,
  input  logic [TAG_W-1:0]        rdTag,
  input  logic                    wrValid,
  output logic                    wrReady,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [LANES*LANE_W-1:0] wrData0,
  input  logic [LANES*LANE_W-1:0] wrData1,
  input  logic [LANES-1:0]        wrMask0,
  input  logic [LANES-1:0]        wrMask1,
  output logic                    rspValid,
  output logic [TAG_W-1:0]        rspTag,
  output logic [LANES*LANE_W-1:0] rspData0,
  output logic [LANES*LANE_W-1:0] rspData1,
  output logic                    devRdSelN,
  output logic                    devWrSelN,
  output logic [ADDR_W-1:0]       devAddrRise,
  output logic [ADDR_W-1:0]       devAddrFall,
  output logic [LANES*LANE_W-1:0] devDataRise,
  output logic [LANES*LANE_W-1:0] devDataFall,
  output logic [LANES-1:0]        devBeRiseN,
  output logic [LANES-1:0]        devBeFallN,
  input  logic [LANES*LANE_W-1:0] devQRise,
  input  logic [LANES*LANE_W-1:0] devQFall
);

  qdrStrobes_t strb;

  qdr2_ctrl #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .RD_LAT(RD_LAT)) uCtrl (
    .clk(clk), .rst(rst), .rdValid(rdValid), .wrValid(wrValid),
    .rdAddr(rdAddr), .wrAddr(wrAddr), .rdTag(rdTag),
    .rdReady(rdReady), .wrReady(wrReady), .strb(strb),
    .devRdSelN(devRdSelN), .devWrSelN(devWrSelN),
    .rspValid(rspValid), .rspTag(rspTag)
  );

  qdr2_datapath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W), .RD_LAT(RD_LAT)) uDp (
    .clk(clk), .rst(rst), .strb(strb), .rdAddr(rdAddr), .wrAddr(wrAddr),
    .wrData0(wrData0), .wrData1(wrData1), .wrMask0(wrMask0), .wrMask1(wrMask1),
    .devQRise(devQRise), .devQFall(devQFall),
    .devAddrRise(devAddrRise), .devAddrFall(devAddrFall),
    .devDataRise(devDataRise), .devDataFall(devDataFall),
    .devBeRiseN(devBeRiseN), .devBeFallN(devBeFallN),
    .rspData0(rspData0), .rspData1(rspData1)
  );

endmodule

// File: rtl/qdr2_burst_ctrl_chk.sv
module qdr2_burst_ctrl_chk #(
  parameter int ADDR_W = 18,
  parameter int LANES  = 2,
  parameter int RD_LAT = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              rdValid,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              wrValid,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [LANES-1:0]  wrMask0,
  input logic [LANES-1:0]  wrMask1,
  input logic              devRdSelN,
  input logic              devWrSelN,
  input logic [ADDR_W-1:0] devAddrRise,
  input logic [ADDR_W-1:0] devAddrFall,
  input logic [LANES-1:0]  devBeRiseN,
  input logic [LANES-1:0]  devBeFallN,
  input logic              rspValid
);

  // Independent record of accepted reads, cleared by reset.
  logic [RD_LAT+1:0] accSh;
  always_ff @(posedge clk) begin
    if (rst) accSh <= '0;
    else     accSh <= {accSh[RD_LAT:0], rdValid};
  end

  assert_rd_select_R2: assert property (@(posedge clk) disable iff (rst)
    rdValid |=> !devRdSelN);
  assert_wr_select_R2: assert property (@(posedge clk) disable iff (rst)
    wrValid |=> !devWrSelN);
  assert_addr_halves_R3: assert property (@(posedge clk) disable iff (rst)
    (rdValid && wrValid) |=> (devAddrRise == $past(rdAddr)) && (devAddrFall == $past(wrAddr)));
  assert_be_invert_R4: assert property (@(posedge clk) disable iff (rst)
    wrValid |=> (devBeRiseN == ~$past(wrMask0)) && (devBeFallN == ~$past(wrMask1)));
  assert_rd_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !rdValid |=> devRdSelN && $stable(devAddrRise));
  assert_wr_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !wrValid |=> devWrSelN && $stable(devAddrFall) && $stable(devBeRiseN) && $stable(devBeFallN));
  assert_rsp_timing_R6: assert property (@(posedge clk) disable iff (rst)
    rspValid == accSh[RD_LAT+1]);

endmodule

bind qdr2_burst_ctrl qdr2_burst_ctrl_chk #(.ADDR_W(ADDR_W), .LANES(LANES), .RD_LAT(RD_LAT)) uChk (
  .clk(clk), .rst(rst), .rdValid(rdValid), .rdAddr(rdAddr), .wrValid(wrValid),
  .wrAddr(wrAddr), .wrMask0(wrMask0), .wrMask1(wrMask1),
  .devRdSelN(devRdSelN), .devWrSelN(devWrSelN), .devAddrRise(devAddrRise),
  .devAddrFall(devAddrFall), .devBeRiseN(devBeRiseN), .devBeFallN(devBeFallN),
  .rspValid(rspValid)
);

// File: tb/sim_qdr2_burst_ctrl.sv
module sim_qdr2_burst_ctrl;

  localparam int AW = 18, LN = 2, LW = 9, TW = 4, LAT = 2;
  localparam int DW = LN * LW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rdValid = 1'b0, wrValid = 1'b0;
  logic [AW-1:0] rdAddr = '0, wrAddr = '0;
  logic [TW-1:0] rdTag = '0;
  logic [DW-1:0] wrData0 = '0, wrData1 = '0;
  logic [LN-1:0] wrMask0 = '0, wrMask1 = '0;
  logic [DW-1:0] devQRise = '0, devQFall = '0;
  logic rdReady, wrReady, rspValid, devRdSelN, devWrSelN;
  logic [TW-1:0] rspTag;
  logic [DW-1:0] rspData0, rspData1, devDataRise, devDataFall;
  logic [AW-1:0] devAddrRise, devAddrFall;
  logic [LN-1:0] devBeRiseN, devBeFallN;

  qdr2_burst_ctrl #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW), .TAG_W(TW), .RD_LAT(LAT)) u0 (
    .clk(clk), .rst(rst), .rdValid(rdValid), .rdReady(rdReady), .rdAddr(rdAddr),
    .rdTag(rdTag), .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr),
    .wrData0(wrData0), .wrData1(wrData1), .wrMask0(wrMask0), .wrMask1(wrMask1),
    .rspValid(rspValid), .rspTag(rspTag), .rspData0(rspData0), .rspData1(rspData1),
    .devRdSelN(devRdSelN), .devWrSelN(devWrSelN), .devAddrRise(devAddrRise),
    .devAddrFall(devAddrFall), .devDataRise(devDataRise), .devDataFall(devDataFall),
    .devBeRiseN(devBeRiseN), .devBeFallN(devBeFallN),
    .devQRise(devQRise), .devQFall(devQFall)
  );

  always #10 clk = ~clk;  // 50 MHz

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc++;

  // Device model memory and bench reference memory: word0 in the upper half.
  logic [2*DW-1:0] devMem [int];
  logic [2*DW-1:0] refMem [int];
  logic [DW-1:0] ringR [8];
  logic [DW-1:0] ringF [8];

  typedef struct {
    int            due;
    logic [TW-1:0] tag;
    logic [DW-1:0] d0, d1;
    string         req;
  } exp_t;
  exp_t expQ[$];

  // Last stimulus and the bus values a correct design must hold.
  bit pRst = 1, pRv = 0, pWv = 0;
  logic [AW-1:0] pRa, pWa, hRa = '0, hWa = '0;
  logic [DW-1:0] pD0, pD1, hD0 = '0, hD1 = '0;
  logic [LN-1:0] pM0, pM1, hB0 = '1, hB1 = '1;

  function automatic logic [2*DW-1:0] initWord(logic [AW-1:0] a);
    return {a * 18'd977 + 18'd11, ~(a ^ 18'h2A5)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  // Device: reads old contents before committing a same-cycle write.
  task automatic devModel();
    logic [2*DW-1:0] w;
    if (!devRdSelN) begin
      w = devMem.exists(int'(devAddrRise)) ? devMem[int'(devAddrRise)] : initWord(devAddrRise);
      ringR[(cyc + LAT) % 8] = w[2*DW-1:DW];
      ringF[(cyc + LAT) % 8] = w[DW-1:0];
    end
    if (!devWrSelN) begin
      w = devMem.exists(int'(devAddrFall)) ? devMem[int'(devAddrFall)] : initWord(devAddrFall);
      for (int l = 0; l < LN; l++) begin
        if (!devBeRiseN[l]) w[DW + l*LW +: LW] = devDataRise[l*LW +: LW];
        if (!devBeFallN[l]) w[l*LW +: LW] = devDataFall[l*LW +: LW];
      end
      devMem[int'(devAddrFall)] = w;
    end
    devQRise = ringR[cyc % 8];
    devQFall = ringF[cyc % 8];
    ringR[cyc % 8] = '1;
    ringF[cyc % 8] = '1;
  endtask

  task automatic monitor();
    exp_t e;
    chk(rdReady == !rst && wrReady == !rst, "R2 ready", {rdReady, wrReady}, {!rst, !rst});
    if (pRst) begin
      chk(devRdSelN && devWrSelN && !rspValid, "R1 reset idle",
          {devRdSelN, devWrSelN, rspValid}, 3'b110);
      chk(devAddrRise == 0 && devAddrFall == 0 && devBeRiseN == '1 && devBeFallN == '1,
          "R1 reset buses", {devAddrRise, devAddrFall}, 0);
    end else begin
      if (pRv) begin
        chk(!devRdSelN, "R2 read select", devRdSelN, 0);
        chk(devAddrRise == pRa, "R3 read address", devAddrRise, pRa);
      end else begin
        chk(devRdSelN && devAddrRise == hRa, "R5 read idle", {devRdSelN, devAddrRise}, {1'b1, hRa});
      end
      if (pWv) begin
        chk(!devWrSelN, "R2 write select", devWrSelN, 0);
        chk(devAddrFall == pWa, "R3 write address", devAddrFall, pWa);
        chk(devDataRise == pD0 && devBeRiseN == ~pM0, "R4 first half",
            {devDataRise, devBeRiseN}, {pD0, ~pM0});
        chk(devDataFall == pD1 && devBeFallN == ~pM1, "R4 second half",
            {devDataFall, devBeFallN}, {pD1, ~pM1});
      end else begin
        chk(devWrSelN && devAddrFall == hWa && devDataRise == hD0 && devDataFall == hD1 &&
            devBeRiseN == hB0 && devBeFallN == hB1, "R5 write idle",
            {devWrSelN, devAddrFall, devDataRise}, {1'b1, hWa, hD0});
      end
    end
    if (expQ.size() > 0 && expQ[0].due == cyc) begin
      e = expQ.pop_front();
      chk(rspValid == 1'b1, {e.req, " valid"}, rspValid, 1);
      chk(rspTag == e.tag && rspData0 == e.d0 && rspData1 == e.d1, e.req,
          {rspTag, rspData0, rspData1}, {e.tag, e.d0, e.d1});
    end else begin
      chk(rspValid == 1'b0, "R6 no spurious response", rspValid, 0);
    end
  endtask

  task automatic apply(input bit r, input bit rv, input logic [AW-1:0] ra, input logic [TW-1:0] tg,
                       input bit wv, input logic [AW-1:0] wa, input logic [DW-1:0] d0,
                       input logic [DW-1:0] d1, input logic [LN-1:0] m0, input logic [LN-1:0] m1);
    exp_t e;
    logic [2*DW-1:0] w;
    rst = r; rdValid = rv; rdAddr = ra; rdTag = tg;
    wrValid = wv; wrAddr = wa; wrData0 = d0; wrData1 = d1; wrMask0 = m0; wrMask1 = m1;
    if (r) begin
      while (expQ.size() > 0 && expQ[expQ.size()-1].due > cyc) void'(expQ.pop_back());
      pRst = 1; pRv = 0; pWv = 0;
      hRa = '0; hWa = '0; hD0 = '0; hD1 = '0; hB0 = '1; hB1 = '1;
      return;
    end
    pRst = 0; pRv = rv; pWv = wv; pRa = ra; pWa = wa; pD0 = d0; pD1 = d1; pM0 = m0; pM1 = m1;
    if (rv) begin
      hRa = ra;
      w = refMem.exists(int'(ra)) ? refMem[int'(ra)] : initWord(ra);
      e.due = cyc + LAT + 2; e.tag = tg; e.d0 = w[2*DW-1:DW]; e.d1 = w[DW-1:0];
      e.req = !wv ? "R6 read" : (wa == ra ? "R7 forward" : "R8 no forward");
      if (wv && wa == ra) begin
        for (int l = 0; l < LN; l++) begin
          if (m0[l]) e.d0[l*LW +: LW] = d0[l*LW +: LW];
          if (m1[l]) e.d1[l*LW +: LW] = d1[l*LW +: LW];
        end
      end
      expQ.push_back(e);
    end
    if (wv) begin
      hWa = wa; hD0 = d0; hD1 = d1; hB0 = ~m0; hB1 = ~m1;
      w = refMem.exists(int'(wa)) ? refMem[int'(wa)] : initWord(wa);
      for (int l = 0; l < LN; l++) begin
        if (m0[l]) w[DW + l*LW +: LW] = d0[l*LW +: LW];
        if (m1[l]) w[l*LW +: LW] = d1[l*LW +: LW];
      end
      refMem[int'(wa)] = w;
    end
  endtask

  task automatic step(input bit r, input bit rv, input logic [AW-1:0] ra, input logic [TW-1:0] tg,
                      input bit wv, input logic [AW-1:0] wa, input logic [DW-1:0] d0,
                      input logic [DW-1:0] d1, input logic [LN-1:0] m0, input logic [LN-1:0] m1);
    @(negedge clk);
    devModel();
    monitor();
    apply(r, rv, ra, tg, wv, wa, d0, d1, m0, m1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) begin ringR[i] = '1; ringF[i] = '1; end
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R6: lone read
    step(0, 1, 18'd5, 4'h1, 0, 0, 0, 0, 0, 0); idle(6);
    // write then read back the same burst
    step(0, 0, 0, 0, 1, 18'd5, 18'h1ABCD, 18'h02345, 2'b11, 2'b11);
    step(0, 1, 18'd5, 4'h2, 0, 0, 0, 0, 0, 0); idle(5);
    // R7: same-cycle same-address, full, split and empty masks
    step(0, 1, 18'd7, 4'h3, 1, 18'd7, 18'h3FFFF, 18'h15555, 2'b11, 2'b11);
    step(0, 1, 18'd8, 4'h4, 1, 18'd8, 18'h2AAAA, 18'h11111, 2'b01, 2'b10);
    step(0, 1, 18'd9, 4'h5, 1, 18'd9, 18'h0F0F0, 18'h30303, 2'b00, 2'b00);
    // R8: different addresses, then a read followed by a write to its address
    step(0, 1, 18'd10, 4'h6, 1, 18'd11, 18'h12121, 18'h23232, 2'b11, 2'b11);
    step(0, 1, 18'd12, 4'h7, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 18'd12, 18'h00777, 18'h00888, 2'b11, 2'b11);
    idle(5);
    // R6: back-to-back read train
    for (int i = 0; i < 5; i++) step(0, 1, AW'(20 + i), TW'(8 + i), 0, 0, 0, 0, 0, 0);
    idle(6);
    // R1: reads in flight across a reset
    step(0, 1, 18'd3, 4'hA, 0, 0, 0, 0, 0, 0);
    step(0, 1, 18'd4, 4'hB, 1, 18'd4, 18'h11223, 18'h33445, 2'b11, 2'b01);
    step(1, 1, 18'd6, 4'hC, 1, 18'd6, 18'h1, 18'h2, 2'b11, 2'b11);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    idle(6);
    // mixed random traffic on a small address window
    for (int i = 0; i < 3000; i++) begin
      step(0, ($urandom % 4) != 0, AW'($urandom % 16), TW'($urandom),
           ($urandom % 3) != 0, AW'($urandom % 16), DW'($urandom), DW'($urandom),
           LN'($urandom), LN'($urandom));
    end
    idle(8);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule